// File: doc/BRIEF.md
# Float32 Normalized Mantissa Extractor

This unit takes one single-precision operand and replaces the low 32-bit lane of a 128-bit vector with that operand's significand rescaled into a chosen interval. The magnitude keeps the operand's fraction bits. The exponent becomes 0 or -1, depending on the interval, the parity of the operand's exponent and the top fraction bit. A two-bit sign code either keeps the sign, clears it, or treats a negative operand as invalid and returns the default quiet NaN. Subnormal operands are first normalized with a leading-zero count. Zeros, infinities and NaNs have their own fixed results.

The computed lane goes through a one-bit writemask. When the mask is enabled and its bit is clear, the lane either keeps a supplied prior destination value or is forced to zero. The upper 96 bits always come from the first source vector.

The datapath is combinational. It classifies the operand, normalizes it and then forms the result. A single register stage holds the 128-bit result and the invalid and denormal flags, so results appear one clock after the inputs. The datapath has no sequencing states. Its behaviour is picked by an enumerated operand class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN.

Top module: `fmx_getmant`

## Requirements
- R1: `imm[1:0]` selects the interval (0: [1,2), 1: [1/2,2), 2: [1/2,1), 3: [3/4,3/2)) and `imm[3:2]` is the sign code. `imm[7:4]` has no effect on any output.
- R2: For a normal operand with interval 0, the result lane has exponent field 127, the operand's 23 fraction bits, and the sign given by the sign code.
- R3: Interval 1 gives exponent field 126 when the unbiased operand exponent is odd (encoded field even) and 127 otherwise.
- R4: Interval 2 always gives exponent field 126.
- R5: Interval 3 gives exponent field 126 when fraction bit 22 (after normalization) is 1 and 127 otherwise.
- R6: Sign code 00 keeps the operand sign and 01 clears it. Codes 10 and 11 clear it for a sign-clear operand. For a sign-set operand that is not zero and not a NaN, codes 10 and 11 give 0x7FC00000 and raise invalid.
- R7: A subnormal operand raises denormal. Its fraction is shifted left by its leading-zero count plus one, and it uses the effective unbiased exponent -127 minus that count for the parity and fraction-bit rules.
- R8: For every interval, zero and infinity give 1.0 (0x3F800000), with bit 31 set only under sign code 00 and a sign-set operand. -0 never gives a NaN.
- R9: A signalling NaN (fraction bit 22 clear, fraction nonzero) returns with bit 22 set and raises invalid. A quiet NaN passes through unchanged with no flag. The sign code does not apply to NaNs.
- R10: The lane is computed when `mask_en` is 0 or `mask_bit` is 1. Otherwise it takes `dst_lo` when `zero_mode` is 0 and 0 when it is 1. Both flags stay low when the lane is not computed.
- R11: `res_vec[127:32]` always equals `src_vec[127:32]`.
- R12: All outputs are registered and show the inputs from the previous rising edge. An active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_vec | input | 128 | First source vector, supplies the upper lanes |
| dst_lo | input | 32 | Prior destination lane, kept under merge masking |
| operand | input | 32 | Float32 operand |
| imm | input | 8 | Control byte: interval and sign code |
| mask_en | input | 1 | Writemask enable |
| mask_bit | input | 1 | Writemask bit for the lane |
| zero_mode | input | 1 | 1 = zero a masked lane, 0 = merge |
| res_vec | output | 128 | Registered result vector |
| flag_invalid | output | 1 | Registered invalid flag |
| flag_denormal | output | 1 | Registered denormal flag |

## Verification
If the unit classifies an operand wrongly, the lane shows the wrong family of result one cycle later. A NaN where 1.0 was due, or a passed-through fraction where a quieted one was due, points straight at the class decision. An error in the parity or leading-zero logic leaves the sign and fraction right, but moves the exponent field between 126 and 127 for some exponents only. That is why the vectors pair neighbouring powers of two and subnormals at several leading-zero counts. A masking fault shows up as a lane or flag that follows the operand when it should have held `dst_lo` or zero, in the cycle right after the mask is applied.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int LZ_W   = $clog2(FRAC_W);

    localparam logic [FP_W-1:0] QNAN_DEFAULT =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fp_class_e;

    typedef enum logic [1:0] {
        IV_ONE_TWO   = 2'd0,
        IV_HALF_TWO  = 2'd1,
        IV_HALF_ONE  = 2'd2,
        IV_3Q_3H     = 2'd3
    } interval_e;

    typedef struct packed {
        fp_class_e         cls;
        logic              sign;
        logic              odd_exp;
        logic [FRAC_W-1:0] frac;
    } fp_norm_t;
endpackage

// File: rtl/fmx_lzc.sv
module fmx_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  d,
    output logic [CW-1:0] cnt
);
    // Scan upward; the highest set bit writes last and wins.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            if (d[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fmx_classify.sv
module fmx_classify
    import fmx_pkg::*;
(
    input  logic [FP_W-1:0] op,
    output fp_norm_t        nrm
);
    logic              sgn;
    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] ff;
    logic [LZ_W-1:0]   lz;
    logic [FRAC_W-1:0] shifted;
    logic              unused_top;

    assign sgn = op[FP_W-1];
    assign ef  = op[FP_W-2:FRAC_W];
    assign ff  = op[FRAC_W-1:0];

    fmx_lzc #(.W(FRAC_W), .CW(LZ_W)) u_lzc (
        .d   (ff),
        .cnt (lz)
    );

    assign shifted    = ff << lz;
    assign unused_top = shifted[FRAC_W-1];

    always_comb begin
        nrm.sign    = sgn;
        nrm.frac    = ff;
        nrm.odd_exp = ef[0] ^ 1'(BIAS & 1);
        if (ef == '1) begin
            if (ff == '0)            nrm.cls = CLS_INF;
            else if (ff[FRAC_W-1])   nrm.cls = CLS_QNAN;
            else                     nrm.cls = CLS_SNAN;
        end else if (ef == '0) begin
            if (ff == '0) begin
                nrm.cls = CLS_ZERO;
            end else begin
                nrm.cls     = CLS_SUB;
                // effective unbiased exponent = -BIAS - lz
                nrm.odd_exp = 1'(BIAS & 1) ^ lz[0];
                nrm.frac    = {shifted[FRAC_W-2:0], 1'b0};
            end
        end else begin
            nrm.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fmx_core.sv
module fmx_core
    import fmx_pkg::*;
(
    input  fp_norm_t        nrm,
    input  logic [FP_W-1:0] op,
    input  logic [3:0]      ctrl,
    output logic [FP_W-1:0] lane,
    output logic            invalid,
    output logic            denormal
);
    interval_e        iv;
    logic [1:0]       sc;
    logic             neg_bad;
    logic             k_m1;
    logic             out_sign;
    logic [EXP_W-1:0] out_exp;

    assign iv       = interval_e'(ctrl[1:0]);
    assign sc       = ctrl[3:2];
    assign neg_bad  = sc[1] & nrm.sign;
    assign out_sign = (sc == 2'b00) ? nrm.sign : 1'b0;
    assign denormal = (nrm.cls == CLS_SUB);

    always_comb begin
        unique case (iv)
            IV_ONE_TWO:  k_m1 = 1'b0;
            IV_HALF_TWO: k_m1 = nrm.odd_exp;
            IV_HALF_ONE: k_m1 = 1'b1;
            IV_3Q_3H:    k_m1 = nrm.frac[FRAC_W-1];
            default:     k_m1 = 1'b0;
        endcase
        out_exp = k_m1 ? EXP_W'(BIAS - 1) : EXP_W'(BIAS);
    end

    always_comb begin
        lane    = '0;
        invalid = 1'b0;
        unique case (nrm.cls)
            CLS_NORM, CLS_SUB: begin
                if (neg_bad) begin
                    lane    = QNAN_DEFAULT;
                    invalid = 1'b1;
                end else begin
                    lane = {out_sign, out_exp, nrm.frac};
                end
            end
            CLS_ZERO: lane = {out_sign, EXP_W'(BIAS), {FRAC_W{1'b0}}};
            CLS_INF: begin
                if (neg_bad) begin
                    lane    = QNAN_DEFAULT;
                    invalid = 1'b1;
                end else begin
                    lane = {out_sign, EXP_W'(BIAS), {FRAC_W{1'b0}}};
                end
            end
            CLS_QNAN: lane = op;
            CLS_SNAN: begin
                lane    = op | (FP_W'(1) << (FRAC_W - 1));
                invalid = 1'b1;
            end
            default: lane = '0;
        endcase
    end

    // Finite, valid results always carry exponent field BIAS or BIAS-1.
    always_comb begin
        if (!$isunknown(lane) && !$isunknown(nrm) && !invalid &&
            (nrm.cls == CLS_NORM || nrm.cls == CLS_SUB)) begin
            AST_EXP_WINDOW: assert (lane[FP_W-2:FRAC_W] == EXP_W'(BIAS) ||
                                    lane[FP_W-2:FRAC_W] == EXP_W'(BIAS - 1))
                else $error("exponent outside window"); // R3
        end
    end
endmodule

// File: rtl/fmx_getmant.sv
module fmx_getmant
    import fmx_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [FP_W-1:0]  dst_lo,
    input  logic [FP_W-1:0]  operand,
    input  logic [7:0]       imm,
    input  logic             mask_en,
    input  logic             mask_bit,
    input  logic             zero_mode,
    output logic [VEC_W-1:0] res_vec,
    output logic             flag_invalid,
    output logic             flag_denormal
);
    localparam int LANE_W = FP_W;

    fp_norm_t          nrm;
    logic [LANE_W-1:0] calc_lane;
    logic              calc_inv;
    logic              calc_den;
    logic              write_lane;
    logic [LANE_W-1:0] next_lane;
    logic              unused_imm_hi;

    assign unused_imm_hi = ^imm[7:4];

    fmx_classify u_cls (
        .op  (operand),
        .nrm (nrm)
    );

    fmx_core u_core (
        .nrm      (nrm),
        .op       (operand),
        .ctrl     (imm[3:0]),
        .lane     (calc_lane),
        .invalid  (calc_inv),
        .denormal (calc_den)
    );

    assign write_lane = ~mask_en | mask_bit;

    always_comb begin
        if (write_lane)     next_lane = calc_lane;
        else if (zero_mode) next_lane = '0;
        else                next_lane = dst_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vec       <= '0;
            flag_invalid  <= 1'b0;
            flag_denormal <= 1'b0;
        end else begin
            res_vec       <= {src_vec[VEC_W-1:LANE_W], next_lane};
            flag_invalid  <= calc_inv & write_lane;
            flag_denormal <= calc_den & write_lane;
        end
    end

    AST_UPPER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> res_vec[VEC_W-1:LANE_W] == $past(src_vec[VEC_W-1:LANE_W])); // R11
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && !mask_bit) |=> (!flag_invalid && !flag_denormal)); // R10
    AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && !mask_bit && zero_mode) |=> res_vec[LANE_W-1:0] == '0); // R10
    AST_MERGE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && !mask_bit && !zero_mode) |=> res_vec[LANE_W-1:0] == $past(dst_lo)); // R10
    AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (res_vec[LANE_W-2:FRAC_W] == '1 && res_vec[FRAC_W-1])); // R9
endmodule

// File: tb/fmx_getmant_tb.sv
`timescale 1ns/1ps
module fmx_getmant_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] src_vec;
    logic [31:0]  dst_lo;
    logic [31:0]  operand;
    logic [7:0]   imm;
    logic         mask_en;
    logic         mask_bit;
    logic         zero_mode;
    logic [127:0] res_vec;
    logic         flag_invalid;
    logic         flag_denormal;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fmx_getmant u_dut (
        .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .dst_lo(dst_lo),
        .operand(operand), .imm(imm), .mask_en(mask_en), .mask_bit(mask_bit),
        .zero_mode(zero_mode), .res_vec(res_vec), .flag_invalid(flag_invalid),
        .flag_denormal(flag_denormal)
    );

    // {operand, imm, expected lane, invalid, denormal, requirement}
    localparam int NV = 34;
    localparam logic [77:0] VT [NV] = '{
        {32'h3F800000, 8'h00, 32'h3F800000, 1'b0, 1'b0, 4'd2},   // R2
        {32'h40000000, 8'h00, 32'h3F800000, 1'b0, 1'b0, 4'd2},   // R2
        {32'h40400000, 8'h00, 32'h3FC00000, 1'b0, 1'b0, 4'd2},   // R2
        {32'hC0400000, 8'h00, 32'hBFC00000, 1'b0, 1'b0, 4'd6},   // R6
        {32'h40000000, 8'h01, 32'h3F000000, 1'b0, 1'b0, 4'd3},   // R3
        {32'h40800000, 8'h01, 32'h3F800000, 1'b0, 1'b0, 4'd3},   // R3
        {32'h40400000, 8'h02, 32'h3F400000, 1'b0, 1'b0, 4'd4},   // R4
        {32'h3F800000, 8'h02, 32'h3F000000, 1'b0, 1'b0, 4'd4},   // R4
        {32'h40400000, 8'h03, 32'h3F400000, 1'b0, 1'b0, 4'd5},   // R5
        {32'h40200000, 8'h03, 32'h3FA00000, 1'b0, 1'b0, 4'd5},   // R5
        {32'h40C00000, 8'h03, 32'h3F400000, 1'b0, 1'b0, 4'd5},   // R5
        {32'hC0400000, 8'h04, 32'h3FC00000, 1'b0, 1'b0, 4'd6},   // R6
        {32'hC0400000, 8'h08, 32'h7FC00000, 1'b1, 1'b0, 4'd6},   // R6
        {32'hC0400000, 8'h0C, 32'h7FC00000, 1'b1, 1'b0, 4'd6},   // R6
        {32'h40400000, 8'h08, 32'h3FC00000, 1'b0, 1'b0, 4'd6},   // R6
        {32'h40400000, 8'hF0, 32'h3FC00000, 1'b0, 1'b0, 4'd1},   // R1
        {32'h40400000, 8'hF2, 32'h3F400000, 1'b0, 1'b0, 4'd1},   // R1
        {32'h00000001, 8'h00, 32'h3F800000, 1'b0, 1'b1, 4'd7},   // R7
        {32'h00000001, 8'h01, 32'h3F000000, 1'b0, 1'b1, 4'd7},   // R7
        {32'h00400000, 8'h01, 32'h3F000000, 1'b0, 1'b1, 4'd7},   // R7
        {32'h00600000, 8'h03, 32'h3F400000, 1'b0, 1'b1, 4'd7},   // R7
        {32'h00200000, 8'h01, 32'h3F800000, 1'b0, 1'b1, 4'd7},   // R7
        {32'h80000001, 8'h08, 32'h7FC00000, 1'b1, 1'b1, 4'd7},   // R7
        {32'h00000000, 8'h00, 32'h3F800000, 1'b0, 1'b0, 4'd8},   // R8
        {32'h80000000, 8'h00, 32'hBF800000, 1'b0, 1'b0, 4'd8},   // R8
        {32'h80000000, 8'h08, 32'h3F800000, 1'b0, 1'b0, 4'd8},   // R8
        {32'h7F800000, 8'h02, 32'h3F800000, 1'b0, 1'b0, 4'd8},   // R8
        {32'hFF800000, 8'h00, 32'hBF800000, 1'b0, 1'b0, 4'd8},   // R8
        {32'hFF800000, 8'h04, 32'h3F800000, 1'b0, 1'b0, 4'd8},   // R8
        {32'hFF800000, 8'h08, 32'h7FC00000, 1'b1, 1'b0, 4'd8},   // R8
        {32'h7F800001, 8'h00, 32'h7FC00001, 1'b1, 1'b0, 4'd9},   // R9
        {32'hFFA00000, 8'h04, 32'hFFE00000, 1'b1, 1'b0, 4'd9},   // R9
        {32'hFFC12345, 8'h08, 32'hFFC12345, 1'b0, 1'b0, 4'd9},   // R9
        {32'hC0C00000, 8'h05, 32'h3FC00000, 1'b0, 1'b0, 4'd3}    // R3
    };

    task automatic chk(input logic [127:0] act, input logic [127:0] exp_v,
                       input int req, input string what);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    task automatic apply(input logic [31:0] op, input logic [7:0] im,
                         input logic me, input logic mb, input logic zm);
        @(negedge clk);
        operand = op; imm = im; mask_en = me; mask_bit = mb; zero_mode = zm;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        src_vec = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h55AA55AA};
        dst_lo = 32'hCAFEF00D; operand = 32'h7F800001; imm = 8'h00;
        mask_en = 1'b0; mask_bit = 1'b0; zero_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_vec, '0, 12, "reset vector");                 // R12
        chk({126'b0, flag_invalid, flag_denormal}, '0, 12, "reset flags");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            src_vec = {32'h11110000 + 32'(i), 96'h0};
            src_vec[95:32] = {32'hA5A50000 ^ 32'(i), 32'h5A5A0000 + 32'(i)};
            apply(VT[i][77:46], VT[i][45:38], 1'b0, 1'b0, 1'b0);
            chk({96'b0, res_vec[31:0]}, {96'b0, VT[i][37:6]}, int'(VT[i][3:0]), "lane");
            chk({126'b0, flag_invalid, flag_denormal},
                {126'b0, VT[i][5], VT[i][4]}, int'(VT[i][3:0]), "flags");
            chk({32'b0, res_vec[127:32]}, {32'b0, src_vec[127:32]}, 11, "upper lanes"); // R11
        end

        // R10 merge masking: sNaN operand would set invalid if computed
        apply(32'h7F800001, 8'h00, 1'b1, 1'b0, 1'b0);
        chk({96'b0, res_vec[31:0]}, {96'b0, dst_lo}, 10, "merge lane");
        chk({126'b0, flag_invalid, flag_denormal}, '0, 10, "merge flags");
        // R10 zeroing masking with a subnormal operand
        apply(32'h00000001, 8'h00, 1'b1, 1'b0, 1'b1);
        chk({96'b0, res_vec[31:0]}, '0, 10, "zero lane");
        chk({126'b0, flag_invalid, flag_denormal}, '0, 10, "zero flags");
        // R10 mask bit set computes
        apply(32'h40400000, 8'h02, 1'b1, 1'b1, 1'b1);
        chk({96'b0, res_vec[31:0]}, {96'b0, 32'h3F400000}, 10, "mask set lane");
        // R10 mask disabled ignores bit and zero mode
        apply(32'h00000001, 8'h00, 1'b0, 1'b0, 1'b1);
        chk({96'b0, res_vec[31:0]}, {96'b0, 32'h3F800000}, 10, "mask off lane");
        chk({127'b0, flag_denormal}, 128'd1, 10, "mask off denormal");

        // R12 one-cycle latency: new inputs not visible before the edge
        @(negedge clk);
        operand = 32'h40000000; imm = 8'h01;
        #1;
        chk({96'b0, res_vec[31:0]}, {96'b0, 32'h3F800000}, 12, "hold before edge");
        @(negedge clk);
        chk({96'b0, res_vec[31:0]}, {96'b0, 32'h3F000000}, 12, "update after edge");
        // R12 reset mid-run
        rst_n = 1'b0;
        #1;
        chk(res_vec, '0, 12, "async reset clears");
        @(negedge clk);
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule